// File: doc/BRIEF.md
# Debug Instruction Stream Aligner

While the core is halted, a debugger feeds it instructions by writing 32-bit words into a single instruction port. Each instruction is either 16 or 32 bits long, and consecutive instructions are packed with no padding. A 32-bit instruction can therefore begin in the second halfword of one write and end in the first halfword of the next write. This block splits each written word into halfwords, upper half first, and classifies each halfword by its leading bits. It rebuilds the instructions that cross a word boundary and hands the core one instruction at a time under a valid/ready handshake.

A status flag reports progress to the debugger. The executed flag drops when an instruction is presented to the core and rises again once the core has taken it. A busy flag tells the debugger to hold its next word. The return-from-debug opcode, when it is a standalone 16-bit instruction, produces a one-cycle exit pulse and clears the debug-state flag. A separate input sets that flag when the core enters the halted state.

Top module: `inject_stream_aligner`

## Requirements
- R1: After a synchronous reset, `insn_valid`, `busy`, `exit_pulse` and `dbg_active` are 0 and `exec_done` is 1.
- R2: A word accepted on `wr_data` yields its bits [31:16] as the first halfword and its bits [15:0] as the second. A word of two 16-bit halfwords (for example 0x0E9C201C) yields two 16-bit instructions in that order. A 16-bit instruction appears on `insn[15:0]` with `insn[31:16]` zero and `insn_long` = 0.
- R3: A halfword is the first half of a 32-bit instruction exactly when its bits [15:13] are 111 and its bits [12:11] are not 00. Every other halfword is a complete 16-bit instruction. For example, 0xE000 is 16-bit and 0xE800 is 32-bit.
- R4: A 32-bit instruction whose first half is the last halfword of one word is completed by the first halfword of the next accepted word. It is presented as {first half, second half} with `insn_long` = 1. The words 0x1896F807 then 0x0046D623 yield 0x1896, 0xF8070046 and 0xD623.
- R5: While `insn_valid` is 1 and `core_ready` is 0, `insn_valid`, `insn` and `insn_long` hold their values. An instruction is consumed on a clock edge where both `insn_valid` and `core_ready` are 1. The next instruction appears no earlier than the following edge.
- R6: `exec_done` goes to 0 on the edge that presents an instruction. It returns to 1 on the edge that consumes that instruction. It is 0 exactly while an instruction is presented.
- R7: `busy` is 1 while an instruction is presented or while the buffered halfwords hold a complete instruction. A write made while `busy` is 1 is ignored and adds nothing to the stream.
- R8: When a 16-bit instruction equal to 0xD623 is consumed, `exit_pulse` is 1 for exactly the next cycle and `dbg_active` is 0 from that cycle on.
- R9: A cycle with `enter_debug` = 1 sets `dbg_active` to 1 on that edge. It takes priority over a clear on the same edge.
- R10: A 32-bit instruction whose second half is 0xD623 (for example 0xF807D623) does not pulse `exit_pulse` and does not clear `dbg_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Word write strobe from the debugger |
| wr_data | input | 32 | Written word, two halfwords, upper first |
| enter_debug | input | 1 | Sets the debug-state flag |
| core_ready | input | 1 | Core accepts the presented instruction |
| busy | output | 1 | Writes are ignored while high |
| insn_valid | output | 1 | An instruction is presented |
| insn | output | 32 | Presented instruction, 16-bit ones zero-extended |
| insn_long | output | 1 | 1 for a 32-bit instruction |
| exec_done | output | 1 | Executed status flag, 1 when idle |
| dbg_active | output | 1 | Debug-state flag |
| exit_pulse | output | 1 | One-cycle pulse after the return opcode completes |

## Verification
The checker watches the following on every cycle:
- the presented instruction is held while the core is not ready;
- the executed flag is the complement of the presented-valid flag;
- `busy` covers every presented instruction;
- the exit pulse lasts one cycle, follows a consumed standalone return opcode and leaves the debug flag cleared;
- the enter input sets that flag.

Only the directed scenarios can show the stream contents. These are the halfword order, the classification of the boundary codes 0xE000 and 0xE800, the reassembly across two writes, and that a write made while busy leaves no trace in later output.

// File: rtl/isa_pkg.sv
package isa_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  typedef logic [HALF_W-1:0] half_t;
  localparam half_t RET_OPCODE = 16'hD623;

  // leading halfword of a 32-bit instruction: three ones, then a non-zero pair
  function automatic logic starts_long(input half_t h);
    return (h[15:13] == 3'b111) && (h[12:11] != 2'b00);
  endfunction
endpackage

// File: rtl/half_queue.sv
module half_queue #(
  parameter int HALF_W = 16,
  parameter int SLOTS  = 3,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [2*HALF_W-1:0] push_word,
  input  logic              pop_one,
  input  logic              pop_two,
  output logic [HALF_W-1:0] head0,
  output logic [HALF_W-1:0] head1,
  output logic [CNT_W-1:0]  count
);
  logic [HALF_W-1:0] slot_q [SLOTS];
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
    end else if (push) begin
      for (int i = 0; i < SLOTS; i++) begin
        if (i == int'(cnt_q))          slot_q[i] <= push_word[2*HALF_W-1:HALF_W];
        else if (i == int'(cnt_q) + 1) slot_q[i] <= push_word[HALF_W-1:0];
      end
      cnt_q <= cnt_q + CNT_W'(2);
    end else if (pop_two) begin
      for (int i = 0; i < SLOTS; i++)
        slot_q[i] <= (i + 2 < SLOTS) ? slot_q[i+2] : '0;
      cnt_q <= cnt_q - CNT_W'(2);
    end else if (pop_one) begin
      for (int i = 0; i < SLOTS; i++)
        slot_q[i] <= (i + 1 < SLOTS) ? slot_q[i+1] : '0;
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign head0 = slot_q[0];
  assign head1 = slot_q[1];
  assign count = cnt_q;
endmodule

// File: rtl/insn_former.sv
module insn_former
  import isa_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  half_t             head0,
  input  half_t             head1,
  input  logic [CNT_W-1:0]  count,
  input  logic              core_ready,
  output logic              have_full,
  output logic              pop_one,
  output logic              pop_two,
  output logic              load_evt,
  output logic              take_evt,
  output logic              insn_valid,
  output logic [WORD_W-1:0] insn,
  output logic              insn_long
);
  logic head_long;
  logic valid_q, long_q;
  logic [WORD_W-1:0] insn_q;

  assign head_long = starts_long(head0);
  assign have_full = (count >= CNT_W'(1)) && (!head_long || count >= CNT_W'(2));
  assign load_evt  = !valid_q && have_full;
  assign take_evt  = valid_q && core_ready;
  assign pop_one   = load_evt && !head_long;
  assign pop_two   = load_evt && head_long;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      long_q  <= 1'b0;
      insn_q  <= '0;
    end else if (take_evt) begin
      valid_q <= 1'b0;
    end else if (load_evt) begin
      valid_q <= 1'b1;
      long_q  <= head_long;
      insn_q  <= head_long ? {head0, head1} : {{HALF_W{1'b0}}, head0};
    end
  end

  assign insn_valid = valid_q;
  assign insn       = insn_q;
  assign insn_long  = long_q;
endmodule

// File: rtl/debug_status.sv
module debug_status (
  input  logic clk,
  input  logic rst,
  input  logic load_evt,
  input  logic take_evt,
  input  logic take_ret,
  input  logic enter_debug,
  input  logic insn_valid,
  input  logic have_full,
  output logic busy,
  output logic exec_done,
  output logic dbg_active,
  output logic exit_pulse
);
  logic exec_q, dbg_q, exit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      exec_q <= 1'b1;
      dbg_q  <= 1'b0;
      exit_q <= 1'b0;
    end else begin
      if (load_evt)      exec_q <= 1'b0;
      else if (take_evt) exec_q <= 1'b1;
      exit_q <= take_ret;
      if (enter_debug)   dbg_q <= 1'b1;
      else if (take_ret) dbg_q <= 1'b0;
    end
  end

  assign busy       = insn_valid || have_full;
  assign exec_done  = exec_q;
  assign dbg_active = dbg_q;
  assign exit_pulse = exit_q;
endmodule

// File: rtl/inject_stream_aligner.sv
module inject_stream_aligner
  import isa_pkg::*;
#(
  parameter int SLOTS = 3,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              enter_debug,
  input  logic              core_ready,
  output logic              busy,
  output logic              insn_valid,
  output logic [WORD_W-1:0] insn,
  output logic              insn_long,
  output logic              exec_done,
  output logic              dbg_active,
  output logic              exit_pulse
);
  half_t            head0, head1;
  logic [CNT_W-1:0] count;
  logic have_full, pop_one, pop_two, load_evt, take_evt, take_ret, accept;

  assign accept   = wr_en && !busy;
  assign take_ret = take_evt && !insn_long && (insn[HALF_W-1:0] == RET_OPCODE);

  half_queue #(.HALF_W(HALF_W), .SLOTS(SLOTS)) u_queue (
    .clk(clk), .rst(rst), .push(accept), .push_word(wr_data),
    .pop_one(pop_one), .pop_two(pop_two),
    .head0(head0), .head1(head1), .count(count)
  );

  insn_former #(.CNT_W(CNT_W)) u_former (
    .clk(clk), .rst(rst), .head0(head0), .head1(head1), .count(count),
    .core_ready(core_ready), .have_full(have_full), .pop_one(pop_one),
    .pop_two(pop_two), .load_evt(load_evt), .take_evt(take_evt),
    .insn_valid(insn_valid), .insn(insn), .insn_long(insn_long)
  );

  debug_status u_status (
    .clk(clk), .rst(rst), .load_evt(load_evt), .take_evt(take_evt),
    .take_ret(take_ret), .enter_debug(enter_debug), .insn_valid(insn_valid),
    .have_full(have_full), .busy(busy), .exec_done(exec_done),
    .dbg_active(dbg_active), .exit_pulse(exit_pulse)
  );
endmodule

// File: rtl/inject_stream_aligner_checker.sv
module inject_stream_aligner_checker (
  input logic        clk,
  input logic        rst,
  input logic        enter_debug,
  input logic        core_ready,
  input logic        busy,
  input logic        insn_valid,
  input logic [31:0] insn,
  input logic        insn_long,
  input logic        exec_done,
  input logic        dbg_active,
  input logic        exit_pulse
);
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    insn_valid && !core_ready |=> insn_valid && $stable(insn) && $stable(insn_long));
  p_exec_flag_r6: assert property (@(posedge clk) disable iff (rst)
    exec_done == !insn_valid);
  p_busy_r7: assert property (@(posedge clk) disable iff (rst)
    insn_valid |-> busy);
  p_exit_cause_r8: assert property (@(posedge clk) disable iff (rst)
    insn_valid && core_ready && !insn_long && insn[15:0] == 16'hD623 |=> exit_pulse);
  p_exit_single_r8: assert property (@(posedge clk) disable iff (rst)
    exit_pulse |=> !exit_pulse);
  p_exit_clears_r8: assert property (@(posedge clk) disable iff (rst)
    exit_pulse && !$past(enter_debug) |-> !dbg_active);
  p_enter_r9: assert property (@(posedge clk) disable iff (rst)
    enter_debug |=> dbg_active);
  p_long_no_exit_r10: assert property (@(posedge clk) disable iff (rst)
    insn_valid && core_ready && insn_long |=> !exit_pulse);
endmodule

bind inject_stream_aligner inject_stream_aligner_checker u_checker (
  .clk(clk), .rst(rst), .enter_debug(enter_debug), .core_ready(core_ready),
  .busy(busy), .insn_valid(insn_valid), .insn(insn), .insn_long(insn_long),
  .exec_done(exec_done), .dbg_active(dbg_active), .exit_pulse(exit_pulse)
);

// File: tb/inject_stream_aligner_bench.sv
module inject_stream_aligner_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic enter_debug = 1'b0;
  logic core_ready = 1'b0;
  logic busy, insn_valid, insn_long, exec_done, dbg_active, exit_pulse;
  logic [31:0] insn;

  int checks = 0;
  int fails = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  inject_stream_aligner u_inject_stream_aligner (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .enter_debug(enter_debug), .core_ready(core_ready), .busy(busy),
    .insn_valid(insn_valid), .insn(insn), .insn_long(insn_long),
    .exec_done(exec_done), .dbg_active(dbg_active), .exit_pulse(exit_pulse)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_word(input logic [31:0] w);
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // wait for a presented instruction, check it, hold, then consume
  task automatic take(input logic [31:0] exp, input logic exp_long, input string tag,
                      output logic exit_seen);
    int n = 0;
    while (!insn_valid && n < 10) begin @(negedge clk); n++; end
    chk(insn_valid, {tag, " valid"}, 32'(insn_valid), 32'd1);
    chk(insn == exp, {tag, " insn"}, insn, exp);
    chk(insn_long == exp_long, {tag, " length"}, 32'(insn_long), 32'(exp_long));
    chk(exec_done == 1'b0, "R6 exec low while presented", 32'(exec_done), 32'd0);
    @(negedge clk);
    chk(insn_valid && insn == exp, "R5 held without ready", insn, exp);
    core_ready = 1'b1;
    @(negedge clk); core_ready = 1'b0;
    chk(exec_done == 1'b1, "R6 exec high after completion", 32'(exec_done), 32'd1);
    chk(insn_valid == 1'b0, "R5 gap after consume", 32'(insn_valid), 32'd0);
    exit_seen = exit_pulse;
  endtask

  task automatic t_reset();
    chk(!insn_valid && !busy && !exit_pulse && !dbg_active, "R1 reset outputs",
        {28'd0, insn_valid, busy, exit_pulse, dbg_active}, 32'd0);
    chk(exec_done == 1'b1, "R1 exec idle", 32'(exec_done), 32'd1);
  endtask

  task automatic t_enter();
    @(negedge clk); enter_debug = 1'b1;
    @(negedge clk); enter_debug = 1'b0;
    chk(dbg_active == 1'b1, "R9 enter sets debug flag", 32'(dbg_active), 32'd1);
  endtask

  task automatic t_two_short();
    logic ex;
    write_word(32'h0E9C201C);
    take(32'h00000E9C, 1'b0, "R2 first half", ex);
    take(32'h0000201C, 1'b0, "R2 second half", ex);
    chk(ex == 1'b0, "R8 no exit on ordinary opcode", 32'(ex), 32'd0);
  endtask

  task automatic t_busy_ignore();
    logic ex;
    write_word(32'h0E9C201C);
    @(negedge clk);
    chk(busy == 1'b1, "R7 busy while pending", 32'(busy), 32'd1);
    write_word(32'h11112222);
    take(32'h00000E9C, 1'b0, "R7 first", ex);
    take(32'h0000201C, 1'b0, "R7 second", ex);
    repeat (4) @(negedge clk);
    chk(insn_valid == 1'b0, "R7 ignored write left no instruction", insn, 32'd0);
    chk(busy == 1'b0, "R7 busy clears", 32'(busy), 32'd0);
  endtask

  task automatic t_boundary_codes();
    logic ex;
    write_word(32'hE000E800);
    take(32'h0000E000, 1'b0, "R3 0xE000 short", ex);
    repeat (2) @(negedge clk);
    chk(busy == 1'b0 && insn_valid == 1'b0, "R3 0xE800 waits for second half",
        {30'd0, busy, insn_valid}, 32'd0);
    write_word(32'h1234ABCD);
    take(32'hE8001234, 1'b1, "R3 0xE800 long", ex);
    take(32'h0000ABCD, 1'b0, "R3 tail short", ex);
  endtask

  task automatic t_long_ret_half();
    logic ex;
    write_word(32'hF807D623);
    take(32'hF807D623, 1'b1, "R10 long with return low half", ex);
    chk(ex == 1'b0, "R10 no exit pulse", 32'(ex), 32'd0);
    chk(dbg_active == 1'b1, "R10 debug flag kept", 32'(dbg_active), 32'd1);
  endtask

  task automatic t_straddle_exit();
    logic ex;
    write_word(32'h1896F807);
    take(32'h00001896, 1'b0, "R4 first", ex);
    write_word(32'h0046D623);
    take(32'hF8070046, 1'b1, "R4 straddling", ex);
    take(32'h0000D623, 1'b0, "R4 return", ex);
    chk(ex == 1'b1, "R8 exit pulse", 32'(ex), 32'd1);
    chk(dbg_active == 1'b0, "R8 debug flag cleared", 32'(dbg_active), 32'd0);
    @(negedge clk);
    chk(exit_pulse == 1'b0, "R8 pulse one cycle", 32'(exit_pulse), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_enter();
    t_two_short();
    t_busy_ignore();
    t_boundary_codes();
    t_long_ret_half();
    t_straddle_exit();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG_CYCLES, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule